// File: doc/BRIEF.md
# Ethernet receive frame tag classifier

This block watches the byte stream of an Ethernet receiver and classifies each frame as it goes past. It counts the bytes of the frame, takes the length/type field and the following tag control field, compares the length/type field with a programmable type value, and recognises 802.1Q tagged frames. Tagged frames with a zero VLAN identifier are reported as priority tagged. At the end of each frame it decides whether the frame is kept or thrown away, based on the frame length, line errors, a bad checksum and the outcome of an external address filter.

The result is a 32-bit status word laid out for a receive buffer descriptor, together with a keep flag. Both are registered and shown with a single-cycle `out_valid` pulse in the cycle after the last byte is accepted. The byte input follows valid/ready rules. `in_ready` is held high because the block needs no buffering, so there is never back-pressure: a byte transfers in every cycle where `in_valid` is high. The result output has no ready. The surrounding logic must take the status word in the cycle where `out_valid` is high.

Top module: `rx_tag_classifier`

## Requirements
- R1: Status bit 22 is set when the frame's length/type field equals `cfg_type_id` and the frame has at least 14 bytes. The length/type field is the big-endian pair formed by the frame bytes at zero-based positions 12 and 13.
- R2: The outcome of the type comparison never changes `out_keep`.
- R3: Status bit 21 is set when the frame has at least 16 bytes and its length/type field equals 0x8100.
- R4: Status bit 20 is set when bit 21 is set and the 12-bit VLAN identifier is 0x000. Bit 20 is never set without bit 21.
- R5: The tag control field is the big-endian pair at positions 14 and 15. Its bits 15:13 are the priority, bit 12 is CFI and bits 11:0 are the VLAN identifier. When bit 21 is set, the priority appears on status bits 19:17 and CFI on status bit 16. Otherwise bits 20:16 are zero.
- R6: A frame longer than 1518 bytes is discarded, or longer than 1536 bytes when `cfg_big_frames` is 1. A frame of exactly the maximum length can be kept.
- R7: A frame shorter than 64 bytes is discarded.
- R8: A frame with `in_rx_er` high on any accepted byte is discarded.
- R9: A frame with `in_fcs_err` high on its end byte is discarded unless `cfg_keep_fcs_err` is 1.
- R10: A frame without the errors of R6 to R9 is kept when `cfg_copy_all` is 1, or when `in_addr_hit` is 1 on its end byte.
- R11: `out_valid` is high for exactly the one cycle after an end byte is accepted. Status bits 31:23 and 15:0 are always zero.
- R12: `in_ready` is always 1. Cycles with `in_valid` low have no effect, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte accepted (always 1) |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_rx_er | input | 1 | Line error on this byte |
| in_fcs_err | input | 1 | Checksum failed, valid with end byte |
| in_addr_hit | input | 1 | Address filter accepted, valid with end byte |
| cfg_type_id | input | 16 | Type value to compare |
| cfg_big_frames | input | 1 | Raise maximum length to 1536 |
| cfg_copy_all | input | 1 | Keep every error-free frame |
| cfg_keep_fcs_err | input | 1 | Keep frames with checksum errors |
| out_valid | output | 1 | Result pulse |
| out_status | output | 32 | Descriptor status word |
| out_keep | output | 1 | Frame is to be kept |

## Verification
The assertions check the following on every cycle:
- the result pulse comes only after an accepted end byte and never lasts two cycles;
- priority tagging implies VLAN tagging;
- the tag fields are zero on untagged frames and the unused status bits stay clear;
- a kept frame never carries a line error;
- the byte counter steps by one per accepted byte.

Only the bench scenarios can show that the field values are decoded from the correct byte positions, that the two length limits fall on the right byte, and that idle cycles carrying junk leave the result unchanged. They can also show that the type match never changes the keep decision, and that the checksum and copy-all settings combine as specified.

// File: rtl/rx_tag_pkg.sv
package rx_tag_pkg;
  localparam int unsigned MIN_LEN     = 64;
  localparam int unsigned STD_MAX_LEN = 1518;
  localparam int unsigned BIG_MAX_LEN = 1536;
  localparam logic [15:0] VLAN_TPID   = 16'h8100;
  localparam int unsigned TYPE_POS    = 12;
  localparam int unsigned TCI_POS     = 14;
  localparam int unsigned BIT_MATCH   = 22;
  localparam int unsigned BIT_VLAN    = 21;
  localparam int unsigned BIT_PRIO    = 20;
  localparam int unsigned BIT_PCP_LO  = 17;
  localparam int unsigned BIT_CFI     = 16;
  localparam logic [31:0] STATUS_USED = 32'h007F_0000;
endpackage

// File: rtl/rx_byte_counter.sv
module rx_byte_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] len_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    idx     = sof ? '0 : cnt_q;
    len_now = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (beat) cnt_q <= len_now;
  end

  // R6: the length count advances by exactly one per mid-frame byte
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R12: idle cycles hold the count
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(cnt_q));
endmodule

// File: rtl/rx_field_capture.sv
module rx_field_capture #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [15:0]      type_v,
  output logic [15:0]      tci_v
);
  import rx_tag_pkg::*;
  localparam int unsigned FIELDS = 4;
  logic [7:0] fld_q [FIELDS];
  logic [7:0] fld_v [FIELDS];

  for (genvar g = 0; g < FIELDS; g++) begin : g_fld
    localparam logic [CNT_W-1:0] POS = CNT_W'(TYPE_POS + g);
    always_comb begin
      fld_v[g] = sof ? 8'h00 : fld_q[g];
      if (beat && idx == POS) fld_v[g] = data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fld_q[g] <= '0;
      else if (beat) fld_q[g] <= fld_v[g];
    end
  end

  assign type_v = {fld_v[0], fld_v[1]};
  assign tci_v  = {fld_v[2], fld_v[3]};
endmodule

// File: rtl/rx_keep_policy.sv
module rx_keep_policy #(
  parameter int unsigned CNT_W = 11
) (
  input  logic [CNT_W-1:0] len,
  input  logic             big_frames,
  input  logic             rx_er,
  input  logic             fcs_err,
  input  logic             keep_fcs_err,
  input  logic             copy_all,
  input  logic             addr_hit,
  output logic             keep
);
  import rx_tag_pkg::*;
  logic too_long, too_short, bad;

  always_comb begin
    too_long  = big_frames ? (len > CNT_W'(BIG_MAX_LEN)) : (len > CNT_W'(STD_MAX_LEN));
    too_short = len < CNT_W'(MIN_LEN);
    bad       = too_long || too_short || rx_er || (fcs_err && !keep_fcs_err);
    keep      = !bad && (copy_all || addr_hit);
  end
endmodule

// File: rtl/rx_tag_classifier.sv
module rx_tag_classifier #(
  parameter int unsigned CNT_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_rx_er,
  input  logic        in_fcs_err,
  input  logic        in_addr_hit,
  input  logic [15:0] cfg_type_id,
  input  logic        cfg_big_frames,
  input  logic        cfg_copy_all,
  input  logic        cfg_keep_fcs_err,
  output logic        out_valid,
  output logic [31:0] out_status,
  output logic        out_keep
);
  import rx_tag_pkg::*;

  logic             beat;
  logic [CNT_W-1:0] idx, len_now;
  logic [15:0]      type_v, tci_v;
  logic             rxer_q, rxer_v, keep_c;
  logic             has_type, has_tci, is_vlan;
  logic [31:0]      status_c;

  assign in_ready = 1'b1;
  assign beat     = in_valid;

  rx_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .idx(idx), .len_now(len_now));

  rx_field_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .idx(idx), .data(in_data), .type_v(type_v), .tci_v(tci_v));

  rx_keep_policy #(.CNT_W(CNT_W)) u_pol (
    .len(len_now), .big_frames(cfg_big_frames), .rx_er(rxer_v),
    .fcs_err(in_fcs_err), .keep_fcs_err(cfg_keep_fcs_err),
    .copy_all(cfg_copy_all), .addr_hit(in_addr_hit), .keep(keep_c));

  always_comb begin
    rxer_v   = (in_sof ? 1'b0 : rxer_q) | in_rx_er;
    has_type = len_now >= CNT_W'(TYPE_POS + 2);
    has_tci  = len_now >= CNT_W'(TCI_POS + 2);
    is_vlan  = has_tci && (type_v == VLAN_TPID);
    status_c = '0;
    status_c[BIT_MATCH] = has_type && (type_v == cfg_type_id);
    status_c[BIT_VLAN]  = is_vlan;
    status_c[BIT_PRIO]  = is_vlan && (tci_v[11:0] == 12'h000);
    if (is_vlan) begin
      status_c[BIT_PCP_LO +: 3] = tci_v[15:13];
      status_c[BIT_CFI]         = tci_v[12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxer_q     <= 1'b0;
      out_valid  <= 1'b0;
      out_status <= '0;
      out_keep   <= 1'b0;
    end else begin
      if (beat) rxer_q <= rxer_v;
      out_valid <= beat && in_eof;
      if (beat && in_eof) begin
        out_status <= status_c;
        out_keep   <= keep_c;
      end
    end
  end

  // R11: a result pulse follows an accepted end byte and lasts one cycle
  assert_pulse_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_eof));
  assert_pulse_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status & ~STATUS_USED) == 32'h0);
  // R4: priority tag implies VLAN tag
  assert_prio_needs_vlan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status[BIT_PRIO]) |-> out_status[BIT_VLAN]);
  // R5: untagged frames carry no tag fields
  assert_untagged_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_status[BIT_VLAN]) |-> out_status[20:16] == 5'd0);
  // R8: a kept frame never saw a line error on its end byte
  assert_keep_no_rxer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_keep) |-> !$past(in_rx_er));
endmodule

// File: tb/rx_tag_classifier_tb.sv
module rx_tag_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0, in_rx_er = 0;
  logic        in_fcs_err = 0, in_addr_hit = 0;
  logic [7:0]  in_data = 0;
  logic [15:0] cfg_type_id = 0;
  logic        cfg_big_frames = 0, cfg_copy_all = 0, cfg_keep_fcs_err = 0;
  logic        in_ready, out_valid, out_keep;
  logic [31:0] out_status;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  rx_tag_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_rx_er(in_rx_er),
    .in_fcs_err(in_fcs_err), .in_addr_hit(in_addr_hit), .cfg_type_id(cfg_type_id),
    .cfg_big_frames(cfg_big_frames), .cfg_copy_all(cfg_copy_all),
    .cfg_keep_fcs_err(cfg_keep_fcs_err), .out_valid(out_valid),
    .out_status(out_status), .out_keep(out_keep));

  function automatic logic [31:0] exp_status(int len, logic [15:0] ty, logic [15:0] tci,
                                             logic [15:0] id);
    logic [31:0] s = 0;
    if (len >= 14 && ty == id) s[22] = 1;
    if (len >= 16 && ty == 16'h8100) begin
      s[21] = 1;
      s[20] = (tci[11:0] == 0);
      s[19:17] = tci[15:13];
      s[16] = tci[12];
    end
    return s;
  endfunction

  function automatic logic exp_keep(int len, logic rxer, logic fcs, logic hit);
    int mx = cfg_big_frames ? 1536 : 1518;
    if (len > mx || len < 64 || rxer) return 0;
    if (fcs && !cfg_keep_fcs_err) return 0;
    return cfg_copy_all || hit;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // rxer_at < 0: no line error; gaps insert idle cycles with junk on the inputs
  task automatic send(string req, int len, logic [15:0] ty, logic [15:0] tci,
                      int rxer_at, logic fcs, logic hit, logic gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom_range(0, 7) == 0)) begin
        @(negedge clk);
        in_valid = 0; in_data = 8'($urandom); in_sof = 1; in_eof = 1;
        in_rx_er = 1; in_fcs_err = 1; in_addr_hit = 1;
      end
      @(negedge clk);
      if (i == 0) check({req, " R11 idle"}, {31'h0, out_valid}, 32'h0);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_rx_er = (i == rxer_at); in_fcs_err = fcs; in_addr_hit = hit;
      case (i)
        12: in_data = ty[15:8];
        13: in_data = ty[7:0];
        14: in_data = tci[15:8];
        15: in_data = tci[7:0];
        default: in_data = 8'($urandom);
      endcase
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_rx_er = 0; in_fcs_err = 0; in_addr_hit = 0;
    check({req, " R11 pulse"}, {31'h0, out_valid}, 32'h1);
    check({req, " status R1 R3 R4 R5"}, out_status, exp_status(len, ty, tci, cfg_type_id));
    check({req, " keep"}, {31'h0, out_keep}, {31'h0, exp_keep(len, rxer_at >= 0, fcs, hit)});
    @(negedge clk);
    check({req, " R11 one cycle"}, {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset", {out_valid, out_keep, 30'h0}, 32'h0);
    check("R11 reset status", out_status, 32'h0);
    check("R12 ready", {31'h0, in_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    cfg_copy_all = 1;
    cfg_type_id = 16'h0800;
    send("R1 match", 64, 16'h0800, 16'h1234, -1, 0, 0, 0);
    send("R3 R5 vlan", 80, 16'h8100, 16'hB005, -1, 0, 0, 0);
    send("R4 prio tag", 70, 16'h8100, 16'h7000, -1, 0, 0, 0);
    cfg_type_id = 16'h8100;
    send("R2 match on bad frame", 63, 16'h8100, 16'h2001, -1, 0, 0, 0);
    send("R7 short", 63, 16'h0800, 0, -1, 0, 0, 0);
    send("R7 min", 64, 16'h0800, 0, -1, 0, 0, 0);
    send("R6 std max", 1518, 16'h0806, 0, -1, 0, 0, 0);
    send("R6 std over", 1519, 16'h0806, 0, -1, 0, 0, 0);
    cfg_big_frames = 1;
    send("R6 big max", 1536, 16'h8100, 16'hE00F, -1, 0, 0, 0);
    send("R6 big over", 1537, 16'h8100, 16'hE00F, -1, 0, 0, 0);
    cfg_big_frames = 0;
    send("R8 rxer first byte", 100, 16'h0800, 0, 0, 0, 0, 0);
    send("R8 rxer last byte", 100, 16'h0800, 0, 99, 0, 0, 0);
    send("R9 fcs drop", 100, 16'h0800, 0, -1, 1, 0, 0);
    cfg_keep_fcs_err = 1;
    send("R9 fcs keep", 100, 16'h0800, 0, -1, 1, 0, 0);
    cfg_copy_all = 0;
    send("R10 no hit", 100, 16'h0800, 0, -1, 0, 0, 0);
    send("R10 hit", 100, 16'h0800, 0, -1, 0, 1, 0);
    send("R1 R3 tiny", 13, 16'h8100, 0, -1, 0, 1, 0);
    send("R3 fifteen", 15, 16'h8100, 0, -1, 0, 1, 0);
    send("R1 single", 1, 16'h0000, 0, -1, 0, 1, 0);
    send("R12 gaps", 120, 16'h8100, 16'h5ABC, -1, 0, 1, 1);
    for (int n = 0; n < 40; n++) begin
      int len = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 1540))
                                            : int'($urandom_range(10, 200));
      logic [15:0] ty = ($urandom_range(0, 1) == 0) ? 16'h8100 : 16'($urandom_range(0, 3));
      logic [15:0] tci = ($urandom_range(0, 2) == 0) ? {4'($urandom), 12'h000} : 16'($urandom);
      int rx = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, len - 1)) : -1;
      cfg_type_id = 16'($urandom_range(0, 3));
      cfg_big_frames = 1'($urandom);
      cfg_copy_all = 1'($urandom);
      cfg_keep_fcs_err = 1'($urandom);
      send("R1 R5 R10 random", len, ty, tci, rx, 1'($urandom_range(0, 3) == 0),
           1'($urandom), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule